// File: doc/BRIEF.md
# DDR2 Burst Data-Phase Scheduler

This block sits in a DDR2 memory controller between the command issue logic and the data path. Each time a READ or WRITE is issued to the device, it works out, in controller clocks, when the data for that command will be on the bus. It then raises a read-capture enable or a write-drive enable for exactly that window. When the command carries the auto-precharge flag, it also pulses a marker in the clock in which the device's self-timed precharge starts.

Read latency is the posted additive latency plus the CAS latency, and write latency is one clock shorter. A burst of 4 beats takes 2 clocks and a burst of 8 beats takes 4, because two beats move per clock. A new command of the same type may cut short a burst that is still running: its window takes over from the point where it begins. A command of the other type whose window would overlap data already scheduled is refused and not scheduled.

Latency and burst length are static settings loaded through a strobe. A load with values outside the legal sets is refused and the old setting stays in force. All outputs are registered.

Top module: `ddr2_burst_sched`

## Requirements
- R1: A READ sampled at rising edge k drives rd_en high in the cycles that follow edges k+RL through k+RL+N-1, where RL = additive latency + CAS latency and N is the burst length in clocks. rd_en is low otherwise.
- R2: A WRITE sampled at edge k drives wr_en high in the cycles that follow edges k+WL through k+WL+N-1, with WL = RL-1.
- R3: cfg_bl8 = 1 selects 8-beat bursts, giving N = 4 clocks. cfg_bl8 = 0 selects 4-beat bursts, giving N = 2 clocks.
- R4: A command of the same type as a burst still in progress is always accepted. The enable follows the old burst up to the start of the new window and then follows the new window. The old window's later cycles are dropped.
- R5: A command with cmd_autopre = 1 makes pre_start pulse for one cycle: the cycle right after the last cycle of its window. A command with cmd_autopre = 0 produces no pulse.
- R6: When a burst is cut short, its precharge pulse is dropped. Only the replacing command's flag decides whether a pulse follows the combined window.
- R7: A READ whose window would overlap a pending write window, or a WRITE whose window would overlap a pending read window, is refused. cmd_rej is high for the cycle after the edge that sampled it. Nothing new is scheduled and the windows already pending are not changed. A command that only abuts the other window is accepted.
- R8: cfg_cl is a binary CAS latency in clocks, legal from 3 to 6. cfg_al is a binary additive latency, legal from 0 to 4. A load with any illegal value raises cfg_err for the cycle after the load edge and leaves the whole previous setting in force. A legal load leaves cfg_err low.
- R9: A setting loaded at edge k applies to commands sampled at edge k+1 and later. A command sampled at the same edge as the load uses the previous setting.
- R10: A synchronous reset clears all pending windows and precharge pulses, drops rd_en, wr_en, pre_start, cfg_err and cmd_rej, and restores CAS latency 3, additive latency 0 and 4-beat bursts.
- R11: rd_en and wr_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load strobe for the latency and burst-length setting |
| cfg_cl | input | 3 | CAS latency in clocks, binary |
| cfg_al | input | 3 | Additive latency in clocks, binary |
| cfg_bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cmd_valid | input | 1 | A READ or WRITE is issued in this cycle |
| cmd_is_wr | input | 1 | 1 for WRITE, 0 for READ |
| cmd_autopre | input | 1 | The command carries the auto-precharge flag |
| rd_en | output | 1 | Read-capture window enable |
| wr_en | output | 1 | Write-drive window enable |
| pre_start | output | 1 | One-cycle pulse where the self-timed precharge begins |
| cfg_err | output | 1 | One-cycle pulse for a refused setting load |
| cmd_rej | output | 1 | One-cycle pulse for a refused command |

## Verification
Two functions can fall on the same edge: a setting load and the issue of a command. The bench drives cfg_load together with a READ in one cycle, to a setting with a much longer latency and the shorter burst. It requires the read window to land where the old latency and old burst length put it. It then issues a second READ and expects the window to move to the new latency and width. A second such pairing is the same-type command that arrives while a window is active. There the bench checks that the merged enable has no gap and no extra cycle, and that the precharge pulse follows only the replacing command's flag.

// File: rtl/ddr2_sched_pkg.sv
`timescale 1ns/1ps
package ddr2_sched_pkg;

  localparam int VEC_MAX = 32;
  localparam int CFG_W   = 3;

  typedef logic [VEC_MAX-1:0] vec_t;

  typedef struct packed {
    logic [CFG_W-1:0] cl;
    logic [CFG_W-1:0] al;
    logic             bl8;
  } sched_cfg_t;

  function automatic int rd_lat(input sched_cfg_t c);
    return int'(c.cl) + int'(c.al);
  endfunction

  function automatic int wr_lat(input sched_cfg_t c);
    return rd_lat(c) - 1;
  endfunction

  function automatic int burst_clks(input sched_cfg_t c, input int short_clks, input int long_clks);
    return c.bl8 ? long_clks : short_clks;
  endfunction

  function automatic logic cfg_ok(input logic [CFG_W-1:0] cl, input logic [CFG_W-1:0] al,
                                  input int cl_min, input int cl_max, input int al_max);
    return (int'(cl) >= cl_min) && (int'(cl) <= cl_max) && (int'(al) <= al_max);
  endfunction

  // bits lo .. lo+n-1 set
  function automatic vec_t span(input int lo, input int n);
    vec_t m;
    m = '0;
    for (int i = 0; i < VEC_MAX; i++) begin
      if (i >= lo && i < lo + n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // bits 0 .. n-1 set
  function automatic vec_t below(input int n);
    return span(0, n);
  endfunction

endpackage

// File: rtl/sched_cfg_reg.sv
`timescale 1ns/1ps
module sched_cfg_reg import ddr2_sched_pkg::*; #(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] cl_in,
  input  logic [CFG_W-1:0] al_in,
  input  logic             bl8_in,
  output sched_cfg_t       cfg,
  output logic             err
);

  logic legal;
  assign legal = cfg_ok(cl_in, al_in, CL_MIN, CL_MAX, AL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.cl  <= CFG_W'(CL_MIN);
      cfg.al  <= '0;
      cfg.bl8 <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= load & ~legal;
      if (load && legal) begin
        cfg.cl  <= cl_in;
        cfg.al  <= al_in;
        cfg.bl8 <= bl8_in;
      end
    end
  end

endmodule

// File: rtl/sched_lane.sv
`timescale 1ns/1ps
module sched_lane import ddr2_sched_pkg::*; #(
  parameter int DEPTH = 15,
  parameter int LAT_W = 4,
  parameter int BL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             autopre,
  input  logic [LAT_W-1:0] lat,
  input  logic [BL_W-1:0]  blen,
  output logic             en,
  output logic             pre,
  output logic [DEPTH-1:0] ahead,
  output logic             cut
);

  // bit j of a vector: event j edges from now
  logic [DEPTH-1:0] win_q, pre_q, win_sh, pre_sh, win_d, pre_d;
  vec_t m_win, m_keep, m_keep_pre, m_pre;

  always_comb begin
    m_win      = span(int'(lat), int'(blen));
    m_keep     = below(int'(lat));
    m_keep_pre = below(int'(lat) + 1);
    m_pre      = span(int'(lat) + int'(blen), 1);
  end

  assign win_sh = win_q >> 1;
  assign pre_sh = pre_q >> 1;

  always_comb begin
    win_d = win_sh;
    pre_d = pre_sh;
    if (issue) begin
      win_d = (win_sh & m_keep[DEPTH-1:0]) | m_win[DEPTH-1:0];
      // pulse exactly at lat belongs to a burst that ended just before the new one
      pre_d = (pre_sh & m_keep_pre[DEPTH-1:0]) | (autopre ? m_pre[DEPTH-1:0] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      pre_q <= '0;
    end else begin
      win_q <= win_d;
      pre_q <= pre_d;
    end
  end

  assign en    = win_q[0];
  assign pre   = pre_q[0];
  assign ahead = win_sh;
  assign cut   = issue & |(win_sh & ~m_keep[DEPTH-1:0]);

endmodule

// File: rtl/ddr2_burst_sched.sv
`timescale 1ns/1ps
module ddr2_burst_sched import ddr2_sched_pkg::*; #(
  parameter int CL_MIN     = 3,
  parameter int CL_MAX     = 6,
  parameter int AL_MAX     = 4,
  parameter int SHORT_CLKS = 2,
  parameter int LONG_CLKS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_load,
  input  logic [2:0] cfg_cl,
  input  logic [2:0] cfg_al,
  input  logic       cfg_bl8,
  input  logic       cmd_valid,
  input  logic       cmd_is_wr,
  input  logic       cmd_autopre,
  output logic       rd_en,
  output logic       wr_en,
  output logic       pre_start,
  output logic       cfg_err,
  output logic       cmd_rej
);

  localparam int MAX_LAT = CL_MAX + AL_MAX;
  localparam int DEPTH   = MAX_LAT + LONG_CLKS + 1;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam int BL_W    = $clog2(LONG_CLKS + 1);

  sched_cfg_t       cfg;
  logic [LAT_W-1:0] rlat, wlat;
  logic [BL_W-1:0]  blen;

  sched_cfg_reg #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .cl_in(cfg_cl), .al_in(cfg_al), .bl8_in(cfg_bl8),
    .cfg(cfg), .err(cfg_err)
  );

  assign rlat = LAT_W'(rd_lat(cfg));
  assign wlat = LAT_W'(wr_lat(cfg));
  assign blen = BL_W'(burst_clks(cfg, SHORT_CLKS, LONG_CLKS));

  // lane 0 = read, lane 1 = write
  logic [LAT_W-1:0] lat_g   [2];
  logic [DEPTH-1:0] ahead_g [2];
  logic [1:0]       req_g, hit_g, go_g, en_g, pre_g, cut_g;

  assign lat_g[0] = rlat;
  assign lat_g[1] = wlat;
  assign req_g    = {cmd_valid & cmd_is_wr, cmd_valid & ~cmd_is_wr};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    vec_t m_req;
    always_comb m_req = span(int'(lat_g[g]), int'(blen));
    assign hit_g[g] = |(m_req[DEPTH-1:0] & ahead_g[1-g]);
    assign go_g[g]  = req_g[g] & ~hit_g[g];

    sched_lane #(.DEPTH(DEPTH), .LAT_W(LAT_W), .BL_W(BL_W)) u_lane (
      .clk(clk), .rst(rst), .issue(go_g[g]), .autopre(cmd_autopre),
      .lat(lat_g[g]), .blen(blen),
      .en(en_g[g]), .pre(pre_g[g]), .ahead(ahead_g[g]), .cut(cut_g[g])
    );
  end

  // named events for the checker
  logic issue_any, reject_now, burst_cut;
  assign issue_any  = |go_g;
  assign reject_now = |(req_g & hit_g);
  assign burst_cut  = |cut_g;

  always_ff @(posedge clk) begin
    if (rst) cmd_rej <= 1'b0;
    else     cmd_rej <= reject_now;
  end

  assign rd_en     = en_g[0];
  assign wr_en     = en_g[1];
  assign pre_start = |pre_g;

endmodule

// File: rtl/ddr2_burst_sched_chk.sv
`timescale 1ns/1ps
module ddr2_burst_sched_chk import ddr2_sched_pkg::*; #(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       rd_en,
  input logic       wr_en,
  input logic       pre_start,
  input logic       cfg_err,
  input logic       cmd_rej,
  input logic       issue_any,
  input sched_cfg_t cur_cfg
);

  AST_NO_DUAL_DIR: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R11

  AST_CFG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(cur_cfg.cl) >= CL_MIN) && (int'(cur_cfg.cl) <= CL_MAX) && (int'(cur_cfg.al) <= AL_MAX)); // R8

  AST_CFG_KEPT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (cur_cfg == $past(cur_cfg))); // R8

  AST_PRE_AFTER_WIN: assert property (@(posedge clk) disable iff (rst)
    pre_start |-> $past(rd_en || wr_en)); // R5

  AST_REJ_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_rej |-> $past(cmd_valid)); // R7

  AST_ISSUE_NOT_REJ: assert property (@(posedge clk) disable iff (rst)
    issue_any |=> !cmd_rej); // R7

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (!rd_en && !wr_en && !pre_start && !cmd_rej && !cfg_err)); // R10

endmodule

bind ddr2_burst_sched ddr2_burst_sched_chk #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .rd_en(rd_en), .wr_en(wr_en),
  .pre_start(pre_start), .cfg_err(cfg_err), .cmd_rej(cmd_rej),
  .issue_any(issue_any), .cur_cfg(cfg)
);

// File: tb/sim_ddr2_burst_sched.sv
`timescale 1ns/1ps
module sim_ddr2_burst_sched;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_cl = 3'd0;
  logic [2:0] cfg_al = 3'd0;
  logic       cfg_bl8 = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_wr = 1'b0;
  logic       cmd_autopre = 1'b0;
  logic       rd_en, wr_en, pre_start, cfg_err, cmd_rej;

  always #5 clk = ~clk;

  ddr2_burst_sched u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_autopre(cmd_autopre), .rd_en(rd_en), .wr_en(wr_en),
    .pre_start(pre_start), .cfg_err(cfg_err), .cmd_rej(cmd_rej)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the setting in force
  int m_cl = 3;
  int m_al = 0;
  bit m_bl8 = 0;

  logic [31:0] rd_t, wr_t, pr_t, rj_t;

  function automatic logic [31:0] mk(input int lo, input int n);
    logic [31:0] m;
    m = '0;
    for (int i = lo; i < lo + n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int rl();
    return m_cl + m_al;
  endfunction

  function automatic int nb();
    return m_bl8 ? 4 : 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input int cl, input int al, input bit bl8);
    bit legal;
    legal = (cl >= 3) && (cl <= 6) && (al <= 4);
    @(negedge clk);
    cfg_load = 1'b1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = bl8;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R8 cfg_err after load", {31'd0, cfg_err}, {31'd0, ~legal});
    if (legal) begin m_cl = cl; m_al = al; m_bl8 = bl8; end
  endtask

  // command A at relative edge 0, optional command B at edge gap,
  // optional setting load on the same edge as A; sample s follows edge s
  task automatic play(input bit a_wr, input bit a_ap, input int gap,
                      input bit b_on, input bit b_wr, input bit b_ap,
                      input bit c_on, input int c_cl, input int c_al, input bit c_bl8);
    rd_t = '0; wr_t = '0; pr_t = '0; rj_t = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = a_wr; cmd_autopre = a_ap;
    if (c_on) begin
      cfg_load = 1'b1; cfg_cl = 3'(c_cl); cfg_al = 3'(c_al); cfg_bl8 = c_bl8;
    end
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cfg_load  = 1'b0;
      rd_t[s] = rd_en; wr_t[s] = wr_en; pr_t[s] = pre_start; rj_t[s] = cmd_rej;
      if (b_on && s == gap - 1) begin
        cmd_valid = 1'b1; cmd_is_wr = b_wr; cmd_autopre = b_ap;
      end
    end
    if (c_on) begin m_cl = c_cl; m_al = c_al; m_bl8 = c_bl8; end
  endtask

  task automatic t_reset_state();
    chk("R10 rd_en after reset", {31'd0, rd_en}, 32'd0);
    chk("R10 wr_en after reset", {31'd0, wr_en}, 32'd0);
    chk("R10 pulses after reset", {29'd0, pre_start, cfg_err, cmd_rej}, 32'd0);
    play(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 default setting read window", rd_t, mk(3, 2));
  endtask

  task automatic t_read_long();
    load_cfg(5, 2, 1);
    play(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 R3 read window CL5 AL2 BL8", rd_t, mk(rl(), nb()));
    chk("R1 no write window", wr_t, 32'd0);
    chk("R5 no pulse without flag", pr_t, 32'd0);
  endtask

  task automatic t_write_autopre();
    play(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 write window WL=RL-1", wr_t, mk(rl() - 1, nb()));
    chk("R5 precharge after write window", pr_t, mk(rl() - 1 + nb(), 1));
  endtask

  task automatic t_short_burst();
    load_cfg(4, 0, 0);
    play(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 R2 short write window", wr_t, mk(3, 2));
    chk("R5 precharge after short window", pr_t, mk(5, 1));
  endtask

  task automatic t_interrupt();
    load_cfg(3, 1, 1);
    play(0, 1, 2, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 read cut by read", rd_t, mk(4, 6));
    chk("R6 cut burst loses precharge", pr_t, 32'd0);
    play(1, 0, 2, 1, 1, 1, 0, 0, 0, 0);
    chk("R4 write cut by write", wr_t, mk(3, 6));
    chk("R6 replacing write precharge", pr_t, mk(9, 1));
  endtask

  task automatic t_conflict();
    play(0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
    chk("R7 read kept on write overlap", rd_t, mk(4, 4));
    chk("R7 overlapping write not scheduled", wr_t, 32'd0);
    chk("R7 reject pulse", rj_t, mk(1, 1));
    play(0, 0, 5, 1, 1, 0, 0, 0, 0, 0);
    chk("R7 abutting write accepted", wr_t, mk(8, 4));
    chk("R7 no reject when abutting", rj_t, 32'd0);
    chk("R11 windows disjoint", rd_t & wr_t, 32'd0);
    play(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 read refused over write", rd_t, 32'd0);
    chk("R7 write kept", wr_t, mk(3, 4));
    chk("R7 reject pulse read", rj_t, mk(1, 1));
  endtask

  task automatic t_bad_cfg();
    load_cfg(7, 0, 0);
    load_cfg(3, 5, 0);
    load_cfg(2, 0, 0);
    play(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 old setting retained", rd_t, mk(4, 4));
  endtask

  task automatic t_same_cycle_cfg();
    play(0, 0, 0, 0, 0, 0, 1, 6, 4, 0);
    chk("R9 command with load uses old setting", rd_t, mk(4, 4));
    play(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 next command uses new setting", rd_t, mk(10, 2));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b0; cmd_autopre = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cl = 3; m_al = 0; m_bl8 = 0;
    rd_t = '0;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      rd_t[s] = rd_en | wr_en | pre_start;
    end
    chk("R10 reset drops pending burst", rd_t, 32'd0);
    play(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 setting restored", rd_t, mk(3, 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_read_long();
    t_write_autopre();
    t_short_burst();
    t_interrupt();
    t_conflict();
    t_bad_cfg();
    t_same_cycle_cfg();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule